// File: doc/BRIEF.md
# DMA Interrupt Register Bank

This block holds the interrupt state of a DMA controller with a parameter number of channels (one to eight). Each channel reports five kinds of event as single-cycle pulses: whole transfer finished, one block finished, source-side transaction finished, destination-side transaction finished, and error. For every kind the bank keeps a per-channel pending vector, a per-channel enable mask, a masked view and a per-bit clear port. It also keeps a summary word showing which kinds have anything unmasked pending, and one registered interrupt line.

The same word-addressed register bus also reaches the channel-enable vector and a global enable. Mask and channel-enable writes carry a write-enable byte above the data byte, so software can change one channel without a read-modify-write. After software turns the global enable off, the bit keeps reading back as set while any channel still reports busy. Software polls it to learn when the engine has drained.

Top module: `dma_irq_bank`

## Requirements
- R1: After reset every pending, mask, channel-enable and global-enable bit reads 0, and `irq_o` is 0.
- R2: An event pulse on channel c of kind k sets pending bit c of kind k at the next clock edge. The bit stays set until software clears it.
- R3: Word address {2'b01,k} (k = 0 transfer, 1 block, 2 source, 3 destination, 4 error) reads pending AND mask for kind k. Address {2'b00,k} reads the pending vector and {2'b10,k} reads the mask. Channel c sits at bit c.
- R4: A write to {2'b10,k} updates mask bit c to wdata[c] only where wdata[8+c] is 1. Every other mask bit keeps its value.
- R5: A write to {2'b11,k} clears each pending bit of kind k whose wdata bit is 1 and leaves the rest alone. If an event pulse for the same bit arrives in the same cycle, the bit ends up set. The clear address reads 0.
- R6: Address 5'h0D reads a summary word whose bit k is 1 when kind k has any bit that is both pending and unmasked.
- R7: `irq_o` is a register that, one cycle after any edge, equals the OR of all masked status bits of all kinds held before that edge.
- R8: Address 5'h05 holds the channel-enable vector and uses the same write-enable byte scheme as R4. `chan_en_o` shows that vector only while the global enable is 1, and is 0 otherwise.
- R9: Bit 0 of address 5'h06 is the global enable. If software writes 0 while it is 1, the bit keeps reading 1 until a clock edge at which no implemented channel is busy. Writing 1 ends the drain at once.
- R10: Bits of channels at or above NCH always read 0, and events or writes cannot set them. Writes to the pending, masked-status and summary addresses change nothing. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 16 | Write data: data byte in 7:0, write-enable byte in 15:8 |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| evt_xfer_i | input | NCH | Transfer-finished pulses, one per channel |
| evt_block_i | input | NCH | Block-finished pulses |
| evt_src_i | input | NCH | Source-transaction pulses |
| evt_dst_i | input | NCH | Destination-transaction pulses |
| evt_err_i | input | NCH | Error pulses |
| chan_busy_i | input | NCH | Per-channel busy indication |
| chan_en_o | output | NCH | Channel enables gated by the global enable |
| irq_o | output | 1 | Registered combined interrupt |

## Verification
The hardest case to reach from the ports is an event pulse landing in the same cycle as a clear of that same bit, together with a drain of the global enable that overlaps busy channels. Directed steps line up each of these on purpose. The clear-plus-event case is tried on a bit that is already set and on one that is not. The drain holds busy across several cycles and then drops it. A seeded random phase mixes sparse events, writes to every address with random enable bytes, and random busy patterns, and checks every address and the interrupt line against a bench model. The bench uses six channels so that the bits of the missing channels can be checked too.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int NTYPE  = 5;
   localparam int MAXCH  = 8;
   localparam int DW     = 16;
   localparam int AW     = 5;

   typedef enum logic [1:0] {
      GRP_PEND = 2'b00,
      GRP_STAT = 2'b01,
      GRP_MASK = 2'b10,
      GRP_CLR  = 2'b11
   } grp_e;

   localparam logic [2:0] SEL_CHEN = 3'd5;
   localparam logic [2:0] SEL_GCFG = 3'd6;
   localparam logic [2:0] SEL_SUM  = 3'd5;
endpackage

// File: rtl/wen_reg.sv
module wen_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] en_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= '0;
      else if (wr_i)
         q <= (q & ~en_i) | (data_i & en_i);
   end

   assign q_o = q;

   // R4
   hold_unenabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((q_o & ~$past(en_i)) == ($past(q_o) & ~$past(en_i))));

   // R4
   take_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> ((q_o & $past(en_i)) == ($past(data_i) & $past(en_i))));
endmodule

// File: rtl/evt_slice.sv
module evt_slice #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] evt_i,
   input  logic [NCH-1:0] clr_i,
   input  logic           mask_wr_i,
   input  logic [NCH-1:0] mask_d_i,
   input  logic [NCH-1:0] mask_en_i,
   output logic [NCH-1:0] pend_o,
   output logic [NCH-1:0] mask_o,
   output logic [NCH-1:0] stat_o
);
   logic [NCH-1:0] pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend <= '0;
      else
         pend <= (pend & ~clr_i) | evt_i;
   end

   wen_reg #(.W(NCH)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (mask_wr_i),
      .data_i(mask_d_i),
      .en_i  (mask_en_i),
      .q_o   (mask_o)
   );

   assign pend_o = pend;
   assign stat_o = pend & mask_o;

   // R2
   evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i)));

   // R5
   clr_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_i & ~evt_i)) |=> ((pend_o & $past(clr_i & ~evt_i)) == '0));

   // R2
   pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i == '0) |=> ((pend_o & $past(pend_o)) == $past(pend_o)));
endmodule

// File: rtl/glob_ctl.sv
module glob_ctl #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_i,
   input  logic           d0_i,
   input  logic [NCH-1:0] busy_i,
   output logic           en_o,
   output logic           rd_bit_o
);
   logic en_q;
   logic drain_q;
   logic any_busy;

   assign any_busy = |busy_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         drain_q <= 1'b0;
      end else begin
         if (wr_i)
            en_q <= d0_i;
         drain_q <= (drain_q | (wr_i & en_q & ~d0_i)) & ~(wr_i & d0_i) & any_busy;
      end
   end

   assign en_o     = en_q;
   assign rd_bit_o = en_q | drain_q;

   // R9
   drain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !d0_i && en_q && any_busy) |=> rd_bit_o);

   // R9
   drain_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_busy && !en_q && !wr_i) |=> !rd_bit_o);
endmodule

// File: rtl/dma_irq_bank.sv
module dma_irq_bank
   import dma_irq_pkg::*;
#(
   parameter int NCH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            bus_wr,
   input  logic [AW-1:0]   bus_addr,
   input  logic [DW-1:0]   bus_wdata,
   output logic [DW-1:0]   bus_rdata,
   input  logic [NCH-1:0]  evt_xfer_i,
   input  logic [NCH-1:0]  evt_block_i,
   input  logic [NCH-1:0]  evt_src_i,
   input  logic [NCH-1:0]  evt_dst_i,
   input  logic [NCH-1:0]  evt_err_i,
   input  logic [NCH-1:0]  chan_busy_i,
   output logic [NCH-1:0]  chan_en_o,
   output logic            irq_o
);
   localparam int PADW = DW - NCH;

   initial begin
      nch_range_chk: assert (NCH >= 1 && NCH <= MAXCH)
         else $error("dma_irq_bank: NCH must be 1..%0d", MAXCH);
   end

   grp_e         grp;
   logic [2:0]   sel;
   logic [NCH-1:0] d_byte;
   logic [NCH-1:0] en_byte;

   assign grp     = grp_e'(bus_addr[4:3]);
   assign sel     = bus_addr[2:0];
   assign d_byte  = bus_wdata[NCH-1:0];
   assign en_byte = bus_wdata[8 +: NCH];

   logic [NCH-1:0] evt_arr  [NTYPE];
   logic [NCH-1:0] pend_arr [NTYPE];
   logic [NCH-1:0] mask_arr [NTYPE];
   logic [NCH-1:0] stat_arr [NTYPE];
   logic [NTYPE-1:0] sum;

   assign evt_arr[0] = evt_xfer_i;
   assign evt_arr[1] = evt_block_i;
   assign evt_arr[2] = evt_src_i;
   assign evt_arr[3] = evt_dst_i;
   assign evt_arr[4] = evt_err_i;

   for (genvar t = 0; t < NTYPE; t++) begin : g_kind
      logic           clr_hit;
      logic           msk_hit;
      logic [NCH-1:0] clr_vec;

      assign clr_hit = bus_wr && (grp == GRP_CLR)  && (sel == 3'(t));
      assign msk_hit = bus_wr && (grp == GRP_MASK) && (sel == 3'(t));
      assign clr_vec = clr_hit ? d_byte : '0;

      evt_slice #(.NCH(NCH)) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .evt_i    (evt_arr[t]),
         .clr_i    (clr_vec),
         .mask_wr_i(msk_hit),
         .mask_d_i (d_byte),
         .mask_en_i(en_byte),
         .pend_o   (pend_arr[t]),
         .mask_o   (mask_arr[t]),
         .stat_o   (stat_arr[t])
      );

      assign sum[t] = |stat_arr[t];
   end

   logic [NCH-1:0] chen_q;
   logic           chen_hit;
   logic           gcfg_hit;
   logic           glob_en;
   logic           glob_rd;

   assign chen_hit = bus_wr && (grp == GRP_PEND) && (sel == SEL_CHEN);
   assign gcfg_hit = bus_wr && (grp == GRP_PEND) && (sel == SEL_GCFG);

   wen_reg #(.W(NCH)) u_chen (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_i  (chen_hit),
      .data_i(d_byte),
      .en_i  (en_byte),
      .q_o   (chen_q)
   );

   glob_ctl #(.NCH(NCH)) u_glob (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (gcfg_hit),
      .d0_i    (bus_wdata[0]),
      .busy_i  (chan_busy_i),
      .en_o    (glob_en),
      .rd_bit_o(glob_rd)
   );

   assign chan_en_o = glob_en ? chen_q : '0;

   logic irq_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_q <= 1'b0;
      else
         irq_q <= |sum;
   end
   assign irq_o = irq_q;

   function automatic logic [DW-1:0] widen(input logic [NCH-1:0] v);
      return {{PADW{1'b0}}, v};
   endfunction

   always_comb begin
      bus_rdata = '0;
      unique case (grp)
         GRP_PEND: begin
            if (sel < 3'(NTYPE))      bus_rdata = widen(pend_arr[sel]);
            else if (sel == SEL_CHEN) bus_rdata = widen(chen_q);
            else if (sel == SEL_GCFG) bus_rdata = {{(DW-1){1'b0}}, glob_rd};
         end
         GRP_STAT: begin
            if (sel < 3'(NTYPE))      bus_rdata = widen(stat_arr[sel]);
            else if (sel == SEL_SUM)  bus_rdata = {{(DW-NTYPE){1'b0}}, sum};
         end
         GRP_MASK: begin
            if (sel < 3'(NTYPE))      bus_rdata = widen(mask_arr[sel]);
         end
         default: bus_rdata = '0;
      endcase
   end

   // R7
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|sum) |=> irq_o);

   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(|sum) |=> !irq_o);

   // R8
   chen_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_rd) |-> (chan_en_o == '0));
endmodule

// File: tb/dma_irq_bank_bench.sv
module dma_irq_bank_bench;
   localparam int NCH = 6;
   localparam logic [7:0] IMPL = 8'h3F;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [NCH-1:0] ev_x = '0, ev_b = '0, ev_s = '0, ev_d = '0, ev_e = '0;
   logic [NCH-1:0] busy = '0;
   logic [NCH-1:0] chan_en_o;
   logic        irq_o;

   always #4 clk = ~clk;

   dma_irq_bank #(.NCH(NCH)) u_dma_irq_bank (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .evt_xfer_i(ev_x), .evt_block_i(ev_b), .evt_src_i(ev_s),
      .evt_dst_i(ev_d), .evt_err_i(ev_e), .chan_busy_i(busy),
      .chan_en_o(chan_en_o), .irq_o(irq_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] m_pend [5];
   logic [7:0] m_mask [5];
   logic [7:0] m_chen;
   logic       m_cfg, m_drain, m_irq;
   logic [7:0] bz_cur = '0;

   task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] model_rd(input logic [4:0] a);
      logic [1:0] g = a[4:3];
      logic [2:0] s = a[2:0];
      logic [15:0] r = '0;
      if (g == 2'b00) begin
         if (s < 5) r = {8'h0, m_pend[s]};
         else if (s == 5) r = {8'h0, m_chen};
         else if (s == 6) r = {15'h0, m_cfg | m_drain};
      end else if (g == 2'b01) begin
         if (s < 5) r = {8'h0, m_pend[s] & m_mask[s]};
         else if (s == 5) for (int t = 0; t < 5; t++) r[t] = |(m_pend[t] & m_mask[t]);
      end else if (g == 2'b10) begin
         if (s < 5) r = {8'h0, m_mask[s]};
      end
      return r;
   endfunction

   task automatic model_step(input logic wr, input logic [4:0] a, input logic [15:0] d,
                             input logic [39:0] ev, input logic [7:0] bz);
      logic [7:0] clr;
      logic wcfg, nd;
      m_irq = 1'b0;
      for (int t = 0; t < 5; t++) m_irq |= |(m_pend[t] & m_mask[t]);
      for (int t = 0; t < 5; t++) begin
         clr = (wr && a == {2'b11, 3'(t)}) ? d[7:0] : 8'h0;
         m_pend[t] = ((m_pend[t] & ~clr) | ev[t*8 +: 8]) & IMPL;
         if (wr && a == {2'b10, 3'(t)})
            m_mask[t] = ((m_mask[t] & ~d[15:8]) | (d[7:0] & d[15:8])) & IMPL;
      end
      if (wr && a == 5'h05)
         m_chen = ((m_chen & ~d[15:8]) | (d[7:0] & d[15:8])) & IMPL;
      wcfg = wr && a == 5'h06;
      nd = (m_drain | (wcfg & m_cfg & ~d[0])) & ~(wcfg & d[0]) & (|(bz & IMPL));
      if (wcfg) m_cfg = d[0];
      m_drain = nd;
   endtask

   task automatic drive(input logic wr, input logic [4:0] a, input logic [15:0] d,
                        input logic [39:0] ev, input logic [7:0] bz);
      bus_wr = wr; bus_addr = a; bus_wdata = d;
      ev_x = ev[0 +: NCH]; ev_b = ev[8 +: NCH]; ev_s = ev[16 +: NCH];
      ev_d = ev[24 +: NCH]; ev_e = ev[32 +: NCH];
      busy = bz[NCH-1:0]; bz_cur = bz;
   endtask

   task automatic cyc(input logic wr, input logic [4:0] a, input logic [15:0] d,
                      input logic [39:0] ev, input logic [7:0] bz);
      @(negedge clk);
      drive(wr, a, d, ev, bz);
      @(posedge clk);
      model_step(wr, a, d, ev, bz);
   endtask

   task automatic rdchk(input logic [4:0] a, input string tag);
      logic [15:0] e;
      @(negedge clk);
      drive(1'b0, a, 16'h0, 40'h0, bz_cur);
      #1;
      e = model_rd(a);
      chk(bus_rdata == e, tag, bus_rdata, e);
      chk(irq_o == m_irq, "R7 irq", {15'h0, irq_o}, {15'h0, m_irq});
      chk(chan_en_o == (m_cfg ? m_chen[NCH-1:0] : '0), "R8 chan_en",
          {10'h0, chan_en_o}, {8'h0, m_cfg ? m_chen : 8'h0});
      @(posedge clk);
      model_step(1'b0, a, 16'h0, 40'h0, bz_cur);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd4242);
      for (int t = 0; t < 5; t++) begin m_pend[t] = '0; m_mask[t] = '0; end
      m_chen = '0; m_cfg = 0; m_drain = 0; m_irq = 0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); model_step(1'b0, 5'h0, 16'h0, 40'h0, 8'h0);

      // R1 reset state
      for (int a = 0; a < 32; a++) rdchk(5'(a), "R1 reset read");

      // R2 event sets pending and holds
      cyc(1'b0, 5'h0, 16'h0, 40'h04_00_00_01_21, 8'h0);
      rdchk(5'h00, "R2 xfer pending");
      rdchk(5'h01, "R2 block pending");
      rdchk(5'h04, "R2 err pending");
      rdchk(5'h00, "R2 still held");
      rdchk(5'h08, "R3 masked zero");

      // R4 mask writes with enable byte
      cyc(1'b1, 5'h10, 16'h01_FF, 40'h0, 8'h0);
      rdchk(5'h10, "R4 one bit enabled");
      rdchk(5'h08, "R3 masked xfer");
      rdchk(5'h0D, "R6 summary");
      cyc(1'b1, 5'h10, 16'h20_00, 40'h0, 8'h0);
      rdchk(5'h10, "R4 other bits kept");
      cyc(1'b1, 5'h10, 16'h20_20, 40'h0, 8'h0);
      rdchk(5'h08, "R3 two masked");

      // R5 clear, and clear racing an event
      cyc(1'b1, 5'h18, 16'h00_01, 40'h0, 8'h0);
      rdchk(5'h00, "R5 clear one bit");
      cyc(1'b1, 5'h18, 16'h00_20, 40'h00_00_00_00_20, 8'h0);
      rdchk(5'h00, "R5 event wins over clear (set bit)");
      cyc(1'b1, 5'h18, 16'h00_02, 40'h00_00_00_00_02, 8'h0);
      rdchk(5'h00, "R5 event wins over clear (clear bit)");
      rdchk(5'h18, "R5 clear reads zero");

      // R10 unimplemented channels and read-only addresses
      cyc(1'b1, 5'h12, 16'hFF_FF, 40'h0, 8'h0);
      rdchk(5'h12, "R10 upper mask bits zero");
      cyc(1'b1, 5'h02, 16'hFF_FF, 40'h0, 8'h0);
      rdchk(5'h02, "R10 pending not writable");
      cyc(1'b1, 5'h0D, 16'hFF_FF, 40'h0, 8'h0);
      rdchk(5'h0D, "R10 summary not writable");
      rdchk(5'h1F, "R10 unused address");

      // R8 channel enable and gating
      cyc(1'b1, 5'h05, 16'h0F_05, 40'h0, 8'h0);
      rdchk(5'h05, "R8 chen written");
      cyc(1'b1, 5'h06, 16'h00_01, 40'h0, 8'h0);
      rdchk(5'h06, "R9 enable set");
      cyc(1'b1, 5'h05, 16'h02_02, 40'h0, 8'h0);
      rdchk(5'h05, "R8 single channel set");

      // R9 drain
      cyc(1'b1, 5'h06, 16'h00_00, 40'h0, 8'h08);
      rdchk(5'h06, "R9 drain reads one");
      cyc(1'b0, 5'h00, 16'h0, 40'h0, 8'h08);
      rdchk(5'h06, "R9 drain still one");
      cyc(1'b0, 5'h00, 16'h0, 40'h0, 8'h00);
      rdchk(5'h06, "R9 drain ended");
      cyc(1'b1, 5'h06, 16'h00_00, 40'h0, 8'h00);
      rdchk(5'h06, "R9 idle off");

      // random mix
      cyc(1'b1, 5'h06, 16'h00_01, 40'h0, 8'h0);
      for (int i = 0; i < 600; i++) begin
         logic [39:0] ev;
         logic [4:0]  a;
         ev = {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom};
         a = 5'($urandom_range(0, 31));
         cyc(($urandom_range(0, 2) != 0), a, 16'($urandom), ev, 8'($urandom) & 8'($urandom));
         rdchk(5'($urandom_range(0, 31)), "R3 random read");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule